// File: doc/BRIEF.md
# Prescaled PWM Time-Base Counter

This block is the free-running 16-bit up-counter that paces a pulse-width modulator. It does not run on a derived clock. Every flop sits on the system clock, and the counter advances only in a cycle where a count-enable pulse is high. That pulse comes from one of two places: a tap of a free-running binary prescaler, which divides the system clock by 2, 4, 8, 16, 32, 64 or 128, or the rising edge of an external clock pin after it has been synchronized.

A 3-bit code picks the source. Code 000 gives divide-by-two, which is the rate the surrounding control logic uses coming out of reset. The whole count is driven from a single register onto one 16-bit output, so a word read is always coherent. The low fifteen bits also go to the PWM channel selectors. Software can load the count only while freeze or test mode is asserted. At all other times a write is dropped.

Top module: `pwm_timebase`

## Requirements
- R1: While `rst_n` is low, `count` is 16'h0000. With `src_sel` = 3'b000 held from reset, `count` equals floor(N/2) after the Nth rising clock edge following reset release.
- R2: The prescaler is a 7-bit divider. It is zero at reset and increases by one on every clock. For `src_sel` = k (k from 0 to 6), the count enable is high in the cycle where the low k+1 divider bits are all ones, so the division ratio is 2^(k+1). The counter then rises by one at the next edge.
- R3: With `src_sel` = 3'b111, `ext_clk` passes through a two-flop synchronizer. A low-to-high change of `ext_clk` that is set up before edge A raises `count` by exactly one at edge A+2.
- R4: Each rising edge of `ext_clk` gives exactly one increment, however long the pin then stays high.
- R5: The prescaler never stops and is never reset except by `rst_n`. Changing `src_sel` or writing the count does not move its phase.
- R6: When `frz_en` and `wr_en` are both high at an edge, `count` takes `wr_data` at that edge. This load wins over any count enable in the same cycle.
- R7: When `wr_en` is high and `frz_en` is low, the write is ignored, and `count` follows only the selected enable.
- R8: The count wraps from 16'hFFFF to 16'h0000 on the next enable.
- R9: `pwm_tap` always equals bits [14:0] of `count`. Bit 15 is not exported to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 3 | Count source: 000..110 select divide-by-2..128, 111 selects the external pin |
| ext_clk | input | 1 | External count clock, asynchronous |
| frz_en | input | 1 | Freeze or test mode; while high the count is writable |
| wr_en | input | 1 | Write strobe for the count |
| wr_data | input | 16 | Value loaded on a permitted write |
| count | output | 16 | Coherent full-width count |
| pwm_tap | output | 15 | Count bits [14:0] for the PWM channel selectors |

## Verification
Several conditions are hard to reach from the ports. These include a permitted write that lands in the same cycle as a count enable, a change of source partway through a prescaler period, and a long external high level that must not add counts. Randomized stretches create all three. They switch `src_sel` at random moments, toggle `ext_clk` with irregular high and low lengths, and issue writes with and without freeze. A bench model of the divider phase predicts every cycle. Directed sequences then pin down the exact two-edge synchronizer latency and the wrap from 16'hFFFF.

// File: rtl/ptb_pkg.sv
package ptb_pkg;

    // Counter and prescaler geometry
    parameter int CNT_W  = 16;
    parameter int DIV_W  = 7;
    parameter int SEL_W  = 3;
    parameter int TAP_W  = CNT_W - 1;

    // Select code reserved for the external source
    localparam logic [SEL_W-1:0] SEL_EXT = SEL_W'(DIV_W);

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } presc_st_t;

    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_st_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

endpackage

// File: rtl/ptb_prescaler.sv
module ptb_prescaler
    import ptb_pkg::*;
#(
    parameter int N_TAPS = DIV_W
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [N_TAPS-1:0] tap_en
);

    typedef struct packed {
        logic [N_TAPS-1:0] div;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.div = st_q.div + N_TAPS'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Tap k pulses once per 2^(k+1) cycles, when the low k+1 bits are all ones
    for (genvar k = 0; k < N_TAPS; k++) begin : g_tap
        assign tap_en[k] = &st_q.div[k:0];
    end

endmodule

// File: rtl/ptb_ext_sync.sv
module ptb_ext_sync
    import ptb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ext_in,
    output logic rise
);

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = ext_in;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise = st_q.s2 & ~st_q.s3;

endmodule

// File: rtl/ptb_counter.sv
module ptb_counter
    import ptb_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] value
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cnt = load_val;
        end else if (step) begin
            st_d.cnt = st_q.cnt + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign value = st_q.cnt;

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import ptb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] src_sel,
    input  logic             ext_clk,
    input  logic             frz_en,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count,
    output logic [TAP_W-1:0] pwm_tap
);

    logic [DIV_W-1:0] tap_en;
    logic             ext_rise;
    logic             cnt_en;
    logic             cnt_load;

    ptb_prescaler #(.N_TAPS(DIV_W)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .tap_en (tap_en)
    );

    ptb_ext_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .ext_in (ext_clk),
        .rise   (ext_rise)
    );

    // Source selection: prescaler tap or synchronized external edge
    always_comb begin
        cnt_en = 1'b0;
        for (int k = 0; k < DIV_W; k++) begin
            if (src_sel == SEL_W'(k)) begin
                cnt_en = tap_en[k];
            end
        end
        if (src_sel == SEL_EXT) begin
            cnt_en = ext_rise;
        end
    end

    assign cnt_load = frz_en & wr_en;

    ptb_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (cnt_en),
        .load     (cnt_load),
        .load_val (wr_data),
        .value    (count)
    );

    assign pwm_tap = count[TAP_W-1:0];

endmodule

// File: rtl/ptb_checker.sv
module ptb_checker
    import ptb_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [SEL_W-1:0] src_sel,
    input logic             frz_en,
    input logic             wr_en,
    input logic [CNT_W-1:0] wr_data,
    input logic [CNT_W-1:0] count,
    input logic             cnt_en
);

    // R1: reset leaves the count at zero
    a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> count == '0);

    // R2: divide-by-two enable never fires on two cycles in a row
    a_r2_div2_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == '0 && cnt_en) |=> (src_sel != '0 || !cnt_en));

    // R4: an external edge yields a single-cycle enable
    a_r4_ext_single: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == SEL_EXT && cnt_en) |=> (src_sel != SEL_EXT || !cnt_en));

    // R6: a permitted write loads the data
    a_r6_write_load: assert property (@(posedge clk) disable iff (!rst_n)
        (frz_en && wr_en) |=> count == $past(wr_data));

    // R7: without a permitted write the count moves by the enable only
    a_r7_step_only: assert property (@(posedge clk) disable iff (!rst_n)
        !(frz_en && wr_en) |=> count == $past(count) + CNT_W'($past(cnt_en)));

endmodule

bind pwm_timebase ptb_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_sel (src_sel),
    .frz_en  (frz_en),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .count   (count),
    .cnt_en  (cnt_en)
);

// File: tb/pwm_timebase_tb.sv
module pwm_timebase_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  src_sel = 3'd0;
    logic        ext_clk = 1'b0;
    logic        frz_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = 16'h0;
    logic [15:0] count;
    logic [14:0] pwm_tap;

    int n_tests = 0;
    int n_fail  = 0;

    // Reference state built from the requirements
    logic [6:0]  m_div = '0;
    logic        m_s1 = 0, m_s2 = 0, m_s3 = 0;
    logic [15:0] m_cnt = '0;

    always #4 clk = ~clk;

    pwm_timebase u_dut (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .ext_clk(ext_clk),
        .frz_en(frz_en), .wr_en(wr_en), .wr_data(wr_data),
        .count(count), .pwm_tap(pwm_tap)
    );

    function automatic logic tap_fire(logic [6:0] dv, logic [2:0] sel);
        logic [6:0] mask;
        mask = 7'((8'd2 << sel) - 8'd1);
        return (dv & mask) == mask;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_div = '0; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_cnt = '0;
        end else begin
            logic en;
            en = (src_sel == 3'd7) ? (m_s2 & ~m_s3) : tap_fire(m_div, src_sel);
            if (frz_en && wr_en) m_cnt = wr_data;
            else if (en)         m_cnt = m_cnt + 16'd1;
            m_div = m_div + 7'd1;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_clk;
        end
    end

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step_chk(string req);
        @(negedge clk);
        check(req, count, m_cnt);
        check("R9", {1'b0, pwm_tap}, {1'b0, m_cnt[14:0]});
    endtask

    task automatic wait_neg(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] c0;
        void'($urandom(32'd24681));

        // R1: reset state
        wait_neg(3);
        check("R1", count, 16'h0000);
        rst_n = 1'b1;
        wait_neg(20);
        check("R1", count, 16'd10);
        check("R9", {1'b0, pwm_tap}, 16'd10);

        // R2: each prescaler tap, compared against the phase model
        for (int s = 1; s < 7; s++) begin
            src_sel = 3'(s);
            for (int i = 0; i < 300; i++) step_chk("R2");
        end
        src_sel = 3'd6;
        wait_neg(1);
        c0 = count;
        wait_neg(128);
        check("R2", count, c0 + 16'd1);

        // R3 / R4: external source latency and single count per edge
        src_sel = 3'd7; ext_clk = 1'b0;
        wait_neg(5);
        c0 = count;
        ext_clk = 1'b1;
        wait_neg(2);
        check("R3", count, c0);
        wait_neg(1);
        check("R3", count, c0 + 16'd1);
        wait_neg(12);
        check("R4", count, c0 + 16'd1);
        ext_clk = 1'b0;
        wait_neg(4);
        ext_clk = 1'b1;
        wait_neg(3);
        check("R4", count, c0 + 16'd2);
        ext_clk = 1'b0;

        // R6: freeze write, including a cycle with an enable
        src_sel = 3'd0;
        frz_en = 1'b1; wr_en = 1'b1; wr_data = 16'h5A5A;
        wait_neg(1);
        check("R6", count, 16'h5A5A);
        wr_data = 16'h1234;
        wait_neg(1);
        check("R6", count, 16'h1234);
        wr_en = 1'b0; frz_en = 1'b0;

        // R7: write without freeze is dropped
        src_sel = 3'd6;
        wait_neg(1);
        c0 = count;
        wr_en = 1'b1; wr_data = 16'hBEEF;
        step_chk("R7");
        check("R7", count, c0 + 16'(tap_fire(m_div - 7'd1, 3'd6)));
        wr_en = 1'b0;

        // R8: wrap
        src_sel = 3'd0;
        frz_en = 1'b1; wr_en = 1'b1; wr_data = 16'hFFFF;
        wait_neg(1);
        frz_en = 1'b0; wr_en = 1'b0;
        for (int i = 0; i < 4 && count == 16'hFFFF; i++) wait_neg(1);
        check("R8", count, 16'h0000);
        check("R9", {1'b0, pwm_tap}, 16'h0000);

        // R5 and mixed: random source switching, pin activity and writes
        for (int i = 0; i < 6000; i++) begin
            string tag;
            tag = (frz_en && wr_en) ? "R6" : (wr_en ? "R7" : "R5");
            step_chk(tag);
            if ($urandom_range(0, 40) == 0) src_sel = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 3) == 0) ext_clk = ~ext_clk;
            frz_en  = ($urandom_range(0, 9) == 0);
            wr_en   = ($urandom_range(0, 7) == 0);
            wr_data = 16'($urandom);
            if ($urandom_range(0, 200) == 0) wr_data = 16'hFFFF;
        end
        frz_en = 1'b0; wr_en = 1'b0;
        step_chk("R5");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule